// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer for a Synchronous Buck Controller

This block sequences the start-up and fault recovery of a voltage-mode synchronous step-down controller. A fixed-point counter stands in for the voltage on the soft-start capacitor. From that counter and a set of comparator flags, the block decides what the power stage may do. The flags cover the supply rail, the input rail, the thermal trip and clear points, the over-voltage comparator and the over-current comparator.

The counter rises in two rates. A fast per-tick step applies below the enable level. A slow step applies above it, up to a final level. Three zones of the counter select what the gates may do:

- Below the enable level, both gates stay off.
- Between the enable level and the switch level, only the low-side switch is driven, and only without pre-bias.
- From the switch level upward, full switching runs.

Sinking current and releasing the error-amplifier clamp wait for the end of the ramp.

An over-current during the ramp only raises a current-limit flag. After the ramp it starts a hiccup cycle: the gates go off, the counter drains at the slow rate to the enable level, and the ramp resumes. A thermal trip clears the counter at once. The block holds off until the cool-down flag is seen.

All level changes except the forced clears happen only on a tick enable. The tick enable sets the ramp time against the system clock.

Top module: `softstart_seq`

## Requirements
- R1: While vcc_ok or vin_ok is low and no thermal trip is active, the next clock edge sets ss_level to 0 and status to OFF (code 0), regardless of tick_en.
- R2: In states OFF, RAMP_LS or RAMP_SW with both supplies good, each cycle with tick_en high adds FAST_STEP (35) to ss_level while it is below EN_LVL (500), and SLOW_STEP (10) otherwise. The result saturates at TOP_LVL (4000). A cycle without tick_en leaves ss_level unchanged.
- R3: While ss_level is below EN_LVL, sw_en and ls_only are 0 and status is OFF or THERMAL.
- R4: With EN_LVL <= ss_level < SW_LVL (1100) during the ramp, status is RAMP_LS (code 1) and sw_en is 0. ls_only equals the inverse of prebias.
- R5: With ss_level at or above SW_LVL during the ramp, status is RAMP_SW (code 2) and sw_en is 1. On reaching TOP_LVL, status becomes RUN (code 3). sink_en and clamp_release are 1 only in RUN.
- R6: An over-current in RAMP_SW raises ilim_active in the same cycle. It does not stop the ramp and does not enter hiccup.
- R7: An over-current in RUN moves status to HICCUP (code 4) at the next edge. In HICCUP, hiccup is 1 and sw_en, ls_only and sink_en are 0.
- R8: In HICCUP, each tick subtracts SLOW_STEP from ss_level, clamped at EN_LVL. On reaching EN_LVL, status becomes RAMP_LS and the ramp resumes from there.
- R9: A thermal trip sets status to THERMAL (code 5) and ss_level to 0 at the next edge, with all gate flags off. THERMAL persists after the trip drops until temp_clear is high, then status returns to OFF and the ramp restarts from 0.
- R10: ovp_ls_on follows ovp_det in RAMP_SW and RUN and is 0 in every other state.
- R11: During and after reset, ss_level is 0, status is OFF and every output flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Ramp time-base enable, one cycle wide |
| vcc_ok | input | 1 | Supply rail above its turn-on threshold |
| vin_ok | input | 1 | Input rail above its turn-on threshold |
| prebias | input | 1 | Output already charged at start-up |
| ovp_det | input | 1 | Feedback above the over-voltage threshold |
| ocp_det | input | 1 | Peak or valley current comparator tripped |
| temp_trip | input | 1 | Junction above the shutdown point |
| temp_clear | input | 1 | Junction below the restart point |
| ss_level | output | LVL_W | Soft-start level |
| sw_en | output | 1 | High-side switching allowed |
| ls_only | output | 1 | Low-side switch held on, high side off |
| sink_en | output | 1 | Negative inductor current allowed |
| hiccup | output | 1 | Hiccup discharge in progress |
| clamp_release | output | 1 | Error-amplifier clamp released |
| ilim_active | output | 1 | Constant-current limiting during the ramp |
| ovp_ls_on | output | 1 | Low-side switch forced on for over-voltage |
| status | output | 3 | Sequencer state code |

## Verification
Assertions check on every cycle:
- the forced clear after a supply loss and inside THERMAL;
- that the ramp never falls;
- the hiccup floor at the enable level;
- the step from RUN into HICCUP on over-current;
- that gates stay off below the enable level;
- that sinking is never allowed before the final level;
- mutual exclusion of the low-side-only, switching and hiccup flags.

Only the bench scenarios can show the exact step sizes and rate change, and the pre-bias effect on the low-side zone. They also show the full hiccup drain and resume, the thermal hold-off release, and that a ramp-time over-current leaves the ramp running.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RAMP_LS = 3'd1,
    ST_RAMP_SW = 3'd2,
    ST_RUN     = 3'd3,
    ST_HICCUP  = 3'd4,
    ST_THERMAL = 3'd5
  } ss_state_e;

endpackage

// File: rtl/ss_level_math.sv
module ss_level_math
  import ss_seq_pkg::*;
#(
  parameter int LVL_W     = 13,
  parameter int EN_LVL    = 500,
  parameter int SW_LVL    = 1100,
  parameter int TOP_LVL   = 4000,
  parameter int FAST_STEP = 35,
  parameter int SLOW_STEP = 10
) (
  input  logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] lvl_up,
  output logic [LVL_W-1:0] lvl_dn,
  output logic             dn_floor,
  output ss_state_e        up_zone
);

  localparam int XW = LVL_W + 1;
  localparam logic [XW-1:0]    EN_X   = XW'(EN_LVL);
  localparam logic [XW-1:0]    TOP_X  = XW'(TOP_LVL);
  localparam logic [XW-1:0]    FAST_X = XW'(FAST_STEP);
  localparam logic [XW-1:0]    SLOW_X = XW'(SLOW_STEP);
  localparam logic [XW-1:0]    DN_LIM = XW'(EN_LVL + SLOW_STEP);
  localparam logic [LVL_W-1:0] EN_V   = LVL_W'(EN_LVL);
  localparam logic [LVL_W-1:0] SW_V   = LVL_W'(SW_LVL);
  localparam logic [LVL_W-1:0] TOP_V  = LVL_W'(TOP_LVL);

  logic [XW-1:0] lvl_x;
  logic [XW-1:0] step_up;
  logic [XW-1:0] sum_up;
  logic [XW-1:0] diff_dn;

  // Rising: fast below the enable level, slow above it, saturating at the top.
  always_comb begin
    lvl_x   = {1'b0, level};
    step_up = (lvl_x < EN_X) ? FAST_X : SLOW_X;
    sum_up  = lvl_x + step_up;
    if (sum_up >= TOP_X) lvl_up = TOP_V;
    else                 lvl_up = sum_up[LVL_W-1:0];
  end

  // Falling (hiccup): slow rate, clamped at the enable level.
  always_comb begin
    diff_dn  = lvl_x - SLOW_X;
    dn_floor = (lvl_x <= DN_LIM);
    if (dn_floor) lvl_dn = EN_V;
    else          lvl_dn = diff_dn[LVL_W-1:0];
  end

  // Zone reached by the rising value.
  always_comb begin
    if (lvl_up < EN_V)       up_zone = ST_OFF;
    else if (lvl_up < SW_V)  up_zone = ST_RAMP_LS;
    else if (lvl_up < TOP_V) up_zone = ST_RAMP_SW;
    else                     up_zone = ST_RUN;
  end

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_seq_pkg::*;
#(
  parameter int LVL_W  = 13,
  parameter int EN_LVL = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sup_ok,
  input  logic             t_trip,
  input  logic             t_clear,
  input  logic             ocp,
  input  logic [LVL_W-1:0] lvl_up,
  input  logic [LVL_W-1:0] lvl_dn,
  input  logic             dn_floor,
  input  ss_state_e        up_zone,
  output logic [LVL_W-1:0] level,
  output ss_state_e        state
);

  localparam logic [LVL_W-1:0] EN_V = LVL_W'(EN_LVL);

  ss_state_e        st_q, st_n;
  logic [LVL_W-1:0] lv_q, lv_n;

  always_comb begin
    st_n = st_q;
    lv_n = lv_q;
    if (t_trip) begin
      st_n = ST_THERMAL;
      lv_n = '0;
    end else if (st_q == ST_THERMAL) begin
      lv_n = '0;
      if (t_clear) st_n = ST_OFF;
    end else if (!sup_ok) begin
      st_n = ST_OFF;
      lv_n = '0;
    end else begin
      case (st_q)
        ST_OFF, ST_RAMP_LS, ST_RAMP_SW: begin
          if (tick) begin
            lv_n = lvl_up;
            st_n = up_zone;
          end
        end
        ST_RUN: begin
          if (ocp) st_n = ST_HICCUP;
        end
        ST_HICCUP: begin
          if (tick) begin
            lv_n = lvl_dn;
            if (dn_floor) st_n = ST_RAMP_LS;
          end
        end
        default: begin
          st_n = ST_OFF;
          lv_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
      lv_q <= '0;
    end else begin
      st_q <= st_n;
      lv_q <= lv_n;
    end
  end

  assign level = lv_q;
  assign state = st_q;

  // R1: supply loss clears the level at the next edge
  p_supply_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok) |=> (lv_q == '0));

  // R2: the ramp never falls while supplies hold
  p_ramp_nondec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_OFF || st_q == ST_RAMP_LS || st_q == ST_RAMP_SW) && sup_ok && !t_trip)
      |=> (lv_q >= $past(lv_q)));

  // R7: over-current in RUN starts a hiccup
  p_run_hiccup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && ocp && sup_ok && !t_trip) |=> (st_q == ST_HICCUP));

  // R8: hiccup never drains below the enable level
  p_hiccup_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HICCUP) |-> (lv_q >= EN_V));

  // R9: thermal hold-off keeps the level at zero
  p_thermal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_THERMAL) |-> (lv_q == '0));

endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
  import ss_seq_pkg::*;
(
  input  ss_state_e  state,
  input  logic       prebias,
  input  logic       ocp,
  input  logic       ovp,
  output logic       sw_en,
  output logic       ls_only,
  output logic       sink_en,
  output logic       hiccup,
  output logic       clamp_release,
  output logic       ilim_active,
  output logic       ovp_ls_on,
  output logic [2:0] status
);

  logic switching;

  always_comb begin
    switching     = (state == ST_RAMP_SW) || (state == ST_RUN);
    sw_en         = switching;
    ls_only       = (state == ST_RAMP_LS) && !prebias;
    sink_en       = (state == ST_RUN);
    clamp_release = (state == ST_RUN);
    hiccup        = (state == ST_HICCUP);
    ilim_active   = (state == ST_RAMP_SW) && ocp;
    ovp_ls_on     = switching && ovp;
    status        = state;
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_seq_pkg::*;
#(
  parameter int LVL_W     = 13,
  parameter int EN_LVL    = 500,
  parameter int SW_LVL    = 1100,
  parameter int TOP_LVL   = 4000,
  parameter int FAST_STEP = 35,
  parameter int SLOW_STEP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             vcc_ok,
  input  logic             vin_ok,
  input  logic             prebias,
  input  logic             ovp_det,
  input  logic             ocp_det,
  input  logic             temp_trip,
  input  logic             temp_clear,
  output logic [LVL_W-1:0] ss_level,
  output logic             sw_en,
  output logic             ls_only,
  output logic             sink_en,
  output logic             hiccup,
  output logic             clamp_release,
  output logic             ilim_active,
  output logic             ovp_ls_on,
  output logic [2:0]       status
);

  localparam logic [LVL_W-1:0] EN_V  = LVL_W'(EN_LVL);
  localparam logic [LVL_W-1:0] TOP_V = LVL_W'(TOP_LVL);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [LVL_W-1:0] lvl_up, lvl_dn, level;
  logic             dn_floor;
  ss_state_e        up_zone, state;

  ss_level_math #(
    .LVL_W(LVL_W), .EN_LVL(EN_LVL), .SW_LVL(SW_LVL), .TOP_LVL(TOP_LVL),
    .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)
  ) u_math (
    .level(level), .lvl_up(lvl_up), .lvl_dn(lvl_dn),
    .dn_floor(dn_floor), .up_zone(up_zone)
  );

  ss_seq_fsm #(.LVL_W(LVL_W), .EN_LVL(EN_LVL)) u_fsm (
    .clk(clk), .rst_n(rst_i), .tick(tick_en), .sup_ok(vcc_ok && vin_ok),
    .t_trip(temp_trip), .t_clear(temp_clear), .ocp(ocp_det),
    .lvl_up(lvl_up), .lvl_dn(lvl_dn), .dn_floor(dn_floor), .up_zone(up_zone),
    .level(level), .state(state)
  );

  ss_out_decode u_dec (
    .state(state), .prebias(prebias), .ocp(ocp_det), .ovp(ovp_det),
    .sw_en(sw_en), .ls_only(ls_only), .sink_en(sink_en), .hiccup(hiccup),
    .clamp_release(clamp_release), .ilim_active(ilim_active),
    .ovp_ls_on(ovp_ls_on), .status(status)
  );

  assign ss_level = level;

  // R3: gates stay off below the enable level
  p_gates_off_low_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (ss_level < EN_V) |-> (!sw_en && !ls_only));

  // R5: sinking only at the final level
  p_sink_top_r5: assert property (@(posedge clk) disable iff (!rst_i)
    sink_en |-> (ss_level == TOP_V));

  // R7: gate-related flags are mutually exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({ls_only, sw_en, hiccup}));

endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;

  localparam int LW = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, vcc_ok, vin_ok, prebias, ovp_det, ocp_det, temp_trip, temp_clear;
  logic [LW-1:0] ss_level;
  logic sw_en, ls_only, sink_en, hiccup, clamp_release, ilim_active, ovp_ls_on;
  logic [2:0] status;

  always #2.5 clk = ~clk;

  softstart_seq dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .vcc_ok(vcc_ok), .vin_ok(vin_ok),
    .prebias(prebias), .ovp_det(ovp_det), .ocp_det(ocp_det),
    .temp_trip(temp_trip), .temp_clear(temp_clear),
    .ss_level(ss_level), .sw_en(sw_en), .ls_only(ls_only), .sink_en(sink_en),
    .hiccup(hiccup), .clamp_release(clamp_release), .ilim_active(ilim_active),
    .ovp_ls_on(ovp_ls_on), .status(status)
  );

  typedef struct packed {
    logic vcc, vin, tick, ocp, pb, trip, clr, ovp;
    logic [9:0] n;
    logic [3:0] req;
  } phase_t;

  localparam int NPH = 17;
  localparam phase_t PH [0:NPH-1] = '{
    //  vcc  vin  tck  ocp  pb   trp  clr  ovp  cycles req
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd20, 4'd1},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd10, 4'd1},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd5,  4'd2},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 10'd14, 4'd3},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 10'd10, 4'd4},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd20, 4'd4},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd4,  4'd2},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd40, 4'd5},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 10'd10, 4'd6},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 10'd5,  4'd10},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd300,4'd5},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd3,  4'd7},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd400,4'd8},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 10'd5,  4'd9},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd5,  4'd9},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 10'd20, 4'd9},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd3,  4'd1}
  };

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference state, written from the requirements
  int m_st;
  int m_lv;

  function automatic string rname(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R?";
    endcase
  endfunction

  function automatic int zone_of(input int lv);
    if (lv < 500) return 0;
    if (lv < 1100) return 1;
    if (lv < 4000) return 2;
    return 3;
  endfunction

  task automatic model_edge();
    if (temp_trip) begin m_st = 5; m_lv = 0; end
    else if (m_st == 5) begin m_lv = 0; if (temp_clear) m_st = 0; end
    else if (!(vcc_ok && vin_ok)) begin m_st = 0; m_lv = 0; end
    else if (m_st <= 2) begin
      if (tick_en) begin
        m_lv = (m_lv < 500) ? m_lv + 35 : m_lv + 10;
        if (m_lv > 4000) m_lv = 4000;
        m_st = zone_of(m_lv);
      end
    end else if (m_st == 3) begin
      if (ocp_det) m_st = 4;
    end else if (m_st == 4) begin
      if (tick_en) begin
        m_lv = m_lv - 10;
        if (m_lv <= 500) begin m_lv = 500; m_st = 1; end
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [LW+9:0] act, exp;
    logic e_sw, e_lo, e_sk, e_hc, e_il, e_ov;
    e_sw = (m_st == 2) || (m_st == 3);
    e_lo = (m_st == 1) && !prebias;
    e_sk = (m_st == 3);
    e_hc = (m_st == 4);
    e_il = (m_st == 2) && ocp_det;
    e_ov = e_sw && ovp_det;
    act = {ss_level, status, sw_en, ls_only, sink_en, clamp_release, hiccup, ilim_active, ovp_ls_on};
    exp = {LW'(m_lv), 3'(m_st), e_sw, e_lo, e_sk, e_sk, e_hc, e_il, e_ov};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t level/status/flags actual=%0d/%0d/%b expected=%0d/%0d/%b",
               tag, $time, act[LW+9:10], act[9:7], act[6:0],
               exp[LW+9:10], exp[9:7], exp[6:0]);
    end
  endtask

  task automatic drive(input phase_t p);
    vcc_ok = p.vcc; vin_ok = p.vin; tick_en = p.tick; ocp_det = p.ocp;
    prebias = p.pb; temp_trip = p.trip; temp_clear = p.clr; ovp_det = p.ovp;
  endtask

  // Called at a falling edge: drive, advance one cycle, sample at the next falling edge.
  task automatic step(input phase_t p);
    drive(p);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(rname(int'(p.req)));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    drive('0);
    rst_n = 1'b0;
    m_st = 0; m_lv = 0;
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R11");

    for (int i = 0; i < NPH; i++) begin
      for (int c = 0; c < int'(PH[i].n); c++) step(PH[i]);
    end

    // Mid-run reset clears everything (R11)
    begin
      phase_t r;
      r = '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'd0, 4'd11};
      for (int c = 0; c < 25; c++) step(r);
      rst_n = 1'b0;
      m_st = 0; m_lv = 0;
      #1;
      compare("R11");
      @(negedge clk);
      compare("R11");
      drive('0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      compare("R11");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule